// File: doc/BRIEF.md
# Three-Wire Control Bus Slave

This block lets a microcontroller configure a set of 16-bit control registers over a slow three-wire serial bus. The wires are a bus clock, a mode line and a data line. The block samples all three with the fast system clock through synchronizers, so the bus clock is never used as a clock. When the mode line is low the bus is in address mode. In that mode an 8-bit byte selects a device by its upper six bits, and the lower two bits choose the kind of operation. When the mode line is high the bus is in data mode and carries the register address and the data bytes.

A write consists of three parts: the device address with operation bits 00, a register address byte whose top bit is 0, and then the high and low data bytes. A read takes two steps. First comes the device address with 00, followed by a register address byte whose top bit is 1. Then the device address is sent again with operation bits 11. After that the slave drives a 17-bit frame on the data line: one status bit, followed by the 16 register bits. The register contents are presented to the rest of the chip as one flat vector. Writing register 7Fh restores every register to its default value.

Top module: `tw_ctrl_slave`

## Requirements
- R1: After reset, the first rising bus clock edge only wakes the interface and captures no bit. Bits are captured starting with the next rising edge.
- R2: In address mode, a completed byte selects the device only when bits 7:2 equal DEV_ADDR. Bits 1:0 equal to 00 open a write or read-prepare, and 11 opens a read. With any other address, the data bytes that follow are ignored.
- R3: In data mode after a selected 00 address, a register address byte with bit 7 = 0 is followed by a high data byte and a low data byte. Together they load register address bits 6:0 with {high,low}.
- R4: Bits are captured MSB first, one on each rising bus clock edge.
- R5: In data mode after a selected 00 address, a register address byte with bit 7 = 1 records bits 6:0 as the pending read address and writes nothing.
- R6: After a selected 11 address byte with a read pending, the next 17 rising edges in data mode each present one frame bit on the data line, in this order: a status bit (1 = implemented register), then the 16 register bits MSB first. The read is then no longer pending.
- R7: Addresses NUM_REGS to 7Eh are unimplemented. Reading one gives status 0 and zero data. Writing one changes no register.
- R8: Writing any value to register 7Fh restores every register i to its default 16'h1000 + i*16'h0101.
- R9: Any change of the mode line discards a partly received byte.
- R10: The data line is enabled only while read frame bits are presented. At all other times bus_doe is 0 and bus_dout is 0.
- R11: After reset every register holds its default value and bus_doe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk | input | 1 | Serial bus clock from the master |
| bus_mode | input | 1 | Mode line: 0 address mode, 1 data mode |
| bus_din | input | 1 | Data line as received |
| bus_dout | output | 1 | Data line value driven during a read frame |
| bus_doe | output | 1 | Data line output enable |
| cfg_regs | output | NUM_REGS*16 | Register contents, register i at bits [16*i +: 16] |

## Verification
The bench first sends the wake-up pulse and then a full write. A design that counted the wake-up pulse as a data bit would shift every later byte and write the wrong register. It uses write values that are not bit-palindromes, which exposes LSB-first capture. It also toggles the mode line in the middle of a byte. A design that kept the partial bits would misread the register address that follows. Other cases are a foreign device address, writes and reads to unimplemented addresses, and a read command with nothing pending. These catch slaves that write anyway, drive the line when they should stay silent, or report a wrong status bit. Finally, a write to 7Fh must bring back the defaults of registers that were changed earlier.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int REG_W  = 16;
  localparam int RADDR_W = 7;

  typedef enum logic [1:0] {DS_IDLE, DS_REG, DS_HI, DS_LO} dstate_t;

  function automatic logic [REG_W-1:0] reg_default(input int idx);
    return 16'h1000 + 16'(idx) * 16'h0101;
  endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile
  import tw_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [RADDR_W-1:0]        waddr,
  input  logic [REG_W-1:0]          wdata,
  input  logic                      soft_rst,
  input  logic [RADDR_W-1:0]        raddr,
  output logic [REG_W-1:0]          rdata,
  output logic                      rvalid,
  output logic [NUM_REGS*REG_W-1:0] regs_flat
);
  logic [REG_W-1:0] r [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst || soft_rst)                    r[g] <= reg_default(g);
      else if (we && waddr == RADDR_W'(g))    r[g] <= wdata;
    end
    assign regs_flat[g*REG_W +: REG_W] = r[g];
  end

  always_comb begin
    rvalid = 32'(raddr) < NUM_REGS;
    rdata  = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (raddr == RADDR_W'(i)) rdata = r[i];
  end

  // R8
  soft_restore_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (regs_flat[REG_W-1:0] == reg_default(0)));

  // R7
  unimpl_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we && 32'(waddr) >= NUM_REGS) |=> $stable(regs_flat));
endmodule

// File: rtl/tw_ctrl_slave.sv
module tw_ctrl_slave
  import tw_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR    = 6'h14,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_clk,
  input  logic                      bus_mode,
  input  logic                      bus_din,
  output logic                      bus_dout,
  output logic                      bus_doe,
  output logic [NUM_REGS*REG_W-1:0] cfg_regs
);
  localparam int FRAME_W = REG_W + 1;
  localparam int OCW     = $clog2(FRAME_W + 1);
  localparam logic [RADDR_W-1:0] SRST_ADDR = '1;

  logic clk_s, mode_s, din_s, clk_q, mode_q;
  logic clk_rise, mode_edge;

  tw_sync #(.STAGES(SYNC_STAGES)) u_sclk  (.clk(clk), .rst(rst), .d(bus_clk),  .q(clk_s));
  tw_sync #(.STAGES(SYNC_STAGES)) u_smode (.clk(clk), .rst(rst), .d(bus_mode), .q(mode_s));
  tw_sync #(.STAGES(SYNC_STAGES)) u_sdin  (.clk(clk), .rst(rst), .d(bus_din),  .q(din_s));

  always_ff @(posedge clk) begin
    if (rst) begin clk_q <= 1'b0; mode_q <= 1'b0; end
    else     begin clk_q <= clk_s; mode_q <= mode_s; end
  end
  assign clk_rise  = clk_s & ~clk_q;
  assign mode_edge = mode_s ^ mode_q;

  logic                 woken;
  logic [2:0]           bit_cnt;
  logic [7:0]           shreg, nbyte;
  dstate_t              dstate;
  logic [RADDR_W-1:0]   waddr, raddr;
  logic [7:0]           hi_byte;
  logic [REG_W-1:0]     wdata;
  logic                 we, srst, rd_pend, rd_active;
  logic [FRAME_W-1:0]   out_sh;
  logic [OCW-1:0]       out_cnt;
  logic [REG_W-1:0]     rf_rdata;
  logic                 rf_rvalid;

  assign nbyte = {shreg[6:0], din_s};

  tw_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .soft_rst(srst), .raddr(raddr), .rdata(rf_rdata), .rvalid(rf_rvalid),
    .regs_flat(cfg_regs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      woken <= 1'b0; bit_cnt <= '0; shreg <= '0; dstate <= DS_IDLE;
      waddr <= '0; raddr <= '0; hi_byte <= '0; wdata <= '0;
      we <= 1'b0; srst <= 1'b0; rd_pend <= 1'b0; rd_active <= 1'b0;
      out_sh <= '0; out_cnt <= '0; bus_doe <= 1'b0;
    end else begin
      we   <= 1'b0;
      srst <= 1'b0;
      if (mode_edge) begin
        bit_cnt <= '0;
        if (!mode_s) rd_active <= 1'b0;
      end else if (clk_rise) begin
        if (!woken) begin
          woken <= 1'b1;
        end else begin
          shreg   <= nbyte;
          bit_cnt <= bit_cnt + 3'd1;
          if (rd_active && mode_s) begin
            out_sh  <= {out_sh[FRAME_W-2:0], 1'b0};
            out_cnt <= out_cnt + OCW'(1);
            if (out_cnt == OCW'(FRAME_W - 1)) rd_active <= 1'b0;
          end
          if (bit_cnt == 3'd7) begin
            if (!mode_s) begin
              dstate <= DS_IDLE;
              if (nbyte[7:2] == DEV_ADDR) begin
                if (nbyte[1:0] == 2'b00) dstate <= DS_REG;
                else if (nbyte[1:0] == 2'b11 && rd_pend) begin
                  rd_active <= 1'b1;
                  rd_pend   <= 1'b0;
                  out_sh    <= {rf_rvalid, rf_rvalid ? rf_rdata : '0};
                  out_cnt   <= '0;
                end
              end
            end else begin
              case (dstate)
                DS_REG: begin
                  if (nbyte[7]) begin
                    raddr   <= nbyte[6:0];
                    rd_pend <= 1'b1;
                    dstate  <= DS_IDLE;
                  end else begin
                    waddr  <= nbyte[6:0];
                    dstate <= DS_HI;
                  end
                end
                DS_HI: begin
                  hi_byte <= nbyte;
                  dstate  <= DS_LO;
                end
                DS_LO: begin
                  wdata  <= {hi_byte, nbyte};
                  if (waddr == SRST_ADDR) srst <= 1'b1;
                  else                    we   <= 1'b1;
                  dstate <= DS_IDLE;
                end
                default: dstate <= DS_IDLE;
              endcase
            end
          end
        end
      end
      bus_doe <= rd_active & mode_s & ~mode_edge;
    end
  end

  assign bus_dout = bus_doe & out_sh[FRAME_W-1];

  // R1
  wake_nobit_chk: assert property (@(posedge clk) disable iff (rst)
    !woken |-> (bit_cnt == 3'd0));

  // R9
  mode_abort_chk: assert property (@(posedge clk) disable iff (rst)
    mode_edge |=> (bit_cnt == 3'd0));

  // R6
  frame_len_chk: assert property (@(posedge clk) disable iff (rst)
    rd_active |-> (out_cnt < OCW'(FRAME_W)));

  // R10
  quiet_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_s && !$past(mode_s)) |-> !bus_doe);

  // R10
  quiet_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    !woken |-> !bus_doe);
endmodule

// File: tb/tw_ctrl_slave_test.sv
`timescale 1ns/1ps
module tw_ctrl_slave_test;
  localparam logic [5:0] DEV = 6'h14;
  localparam int HALF = 100;

  logic clk = 0, rst = 1, bus_clk = 0, bus_mode = 0, bus_din = 0;
  logic bus_dout, bus_doe;
  logic [127:0] cfg_regs;
  int checks = 0, fails = 0;
  logic [16:0] exp_q[$];
  logic [16:0] cap = '0;
  int ncap = 0;

  always #5 clk = ~clk;

  tw_ctrl_slave uut (
    .clk(clk), .rst(rst), .bus_clk(bus_clk), .bus_mode(bus_mode),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe), .cfg_regs(cfg_regs)
  );

  function automatic logic [15:0] dflt(input int i);
    return 16'h1000 + 16'(i) * 16'h0101;
  endfunction

  function automatic logic [15:0] rg(input int i);
    return cfg_regs[i*16 +: 16];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: assembles driven frames and compares them with the scoreboard
  always @(posedge bus_clk) begin
    if (bus_doe) begin
      cap = {cap[15:0], bus_dout};
      ncap++;
      if (ncap == 17) begin
        ncap = 0;
        if (exp_q.size() == 0) check(0, "R10 unexpected read frame", 32'(cap), 0);
        else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          check(cap == e, "R6/R7 read frame", 32'(cap), 32'(e));
        end
      end
    end
  end

  task automatic pulse(input logic b);
    bus_din = b; #HALF; bus_clk = 1; #HALF; bus_clk = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) pulse(b[i]);
  endtask

  task automatic set_mode(input logic m);
    #HALF; bus_mode = m; #HALF;
  endtask

  task automatic write_reg(input logic [5:0] dev, input logic [6:0] a, input logic [15:0] d);
    set_mode(0); send_byte({dev, 2'b00});
    set_mode(1); send_byte({1'b0, a}); send_byte(d[15:8]); send_byte(d[7:0]);
    set_mode(0);
  endtask

  // driver: pushes the expected frame and clocks the read out
  task automatic read_reg(input logic [6:0] a, input logic [16:0] e);
    set_mode(0); send_byte({DEV, 2'b00});
    set_mode(1); send_byte({1'b1, a});
    set_mode(0); send_byte({DEV, 2'b11});
    exp_q.push_back(e);
    set_mode(1); repeat (17) pulse(0);
    set_mode(0);
  endtask

  initial begin
    #(200000 * 10);
    check(0, "watchdog", 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
    // R11 reset state
    check(bus_doe == 0, "R11 doe after reset", 32'(bus_doe), 0);
    check(rg(0) == dflt(0), "R11 reg0 default", 32'(rg(0)), 32'(dflt(0)));
    check(rg(7) == dflt(7), "R11 reg7 default", 32'(rg(7)), 32'(dflt(7)));

    // R1 wake pulse, then a write that must land aligned (R3, R4)
    pulse(1);
    write_reg(DEV, 7'd2, 16'hA55A);
    check(rg(2) == 16'hA55A, "R1/R3 write reg2", 32'(rg(2)), 32'hA55A);
    check(bus_doe == 0, "R10 no drive during write", 32'(bus_doe), 0);
    write_reg(DEV, 7'd7, 16'hC035);
    check(rg(7) == 16'hC035, "R4 msb-first reg7", 32'(rg(7)), 32'hC035);

    // R2 foreign device address
    write_reg(DEV ^ 6'h01, 7'd3, 16'hFFFF);
    check(rg(3) == dflt(3), "R2 foreign address ignored", 32'(rg(3)), 32'(dflt(3)));

    // R7 unimplemented write
    write_reg(DEV, 7'h10, 16'h0F0F);
    check(rg(0) == dflt(0), "R7 unimpl write reg0", 32'(rg(0)), 32'(dflt(0)));
    check(rg(2) == 16'hA55A, "R7 unimpl write reg2", 32'(rg(2)), 32'hA55A);

    // R9 partial byte aborted by mode change
    set_mode(0); send_byte({DEV, 2'b00});
    set_mode(1); repeat (5) pulse(1);
    set_mode(0); set_mode(1);
    send_byte({1'b0, 7'd4}); send_byte(8'h12); send_byte(8'h34);
    set_mode(0);
    check(rg(4) == 16'h1234, "R9 abort partial byte", 32'(rg(4)), 32'h1234);

    // R5 R6 reads
    read_reg(7'd2, {1'b1, 16'hA55A});
    read_reg(7'd5, {1'b1, dflt(5)});
    check(rg(2) == 16'hA55A, "R5 read prepare writes nothing", 32'(rg(2)), 32'hA55A);
    // R7 unimplemented read
    read_reg(7'h20, 17'h0);

    // R6/R10 read command with nothing pending
    set_mode(0); send_byte({DEV, 2'b11});
    set_mode(1);
    for (int i = 0; i < 17; i++) begin
      pulse(0);
      if (i == 3) check(bus_doe == 0, "R10 no pending read", 32'(bus_doe), 0);
    end
    set_mode(0);

    // R8 software restore
    write_reg(DEV, 7'h7F, 16'h0000);
    check(rg(2) == dflt(2), "R8 reg2 restored", 32'(rg(2)), 32'(dflt(2)));
    check(rg(4) == dflt(4), "R8 reg4 restored", 32'(rg(4)), 32'(dflt(4)));
    check(rg(7) == dflt(7), "R8 reg7 restored", 32'(rg(7)), 32'(dflt(7)));

    check(exp_q.size() == 0, "R6 all frames seen", 32'(exp_q.size()), 0);
    check(bus_doe == 0, "R10 idle at end", 32'(bus_doe), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule